// File: doc/BRIEF.md
# Full-Duplex Three-Wire Serial Master

This block is a serial master for a three-wire bus: a clock it drives, a data line it drives, and a data line it samples. One start pulse runs a transfer of 1 to 255 bits. The outgoing bits are taken from an internal byte store, most significant bit first. In the same transfer, each incoming bit is written back into the store at the position of the bit that was just sent. When the transfer finishes, the store holds the received data in place of the sent data.

The host fills and reads the store through a simple write port and an asynchronous read port. Before it starts a transfer, the host chooses four things: the bit count, which clock edge launches data, one of three bit rates, and which of the chip-select lines addresses the target. One chip select is active for the whole of a transfer, with one bit period of margin on each side of the clock burst. A one-cycle done pulse marks the end.

Top module: `ser3w_master`

## Requirements
- R1: After reset, every chip-select line is high, `sclk` is 0, `mosi` is 0, and `busy` and `done` are 0.
- R2: With `edge_sel`=0 data launches on rising `sclk` edges and is captured on falling edges; with `edge_sel`=1 the reverse. While idle, `sclk` rests at the level `edge_sel` had on the previous clock (low for 0, high for 1), so the first edge of a transfer is a launch edge. A transfer of N bits makes exactly 2N `sclk` edges.
- R3: Bit i (i = 0 .. N-1) sent on `mosi` is bit 7-(i mod 8) of store byte i/8. `mosi` changes only on a launch edge and holds its last value between transfers.
- R4: The `miso` level present at the capture edge of bit i replaces bit 7-(i mod 8) of store byte i/8. Bits beyond bit N-1 in the last byte are unspecified. Bytes past the last byte are unchanged.
- R5: Let H be the half-period in system clocks. If start is accepted at clock edge c0, the chip select drops and `busy` rises at c0. `sclk` toggles at c0+(2+k)H for k = 0 .. 2N-1. Chip select and `busy` return at c0+(2N+3)H.
- R6: `rate_sel` 0, 1, 2 give H = `H_SLOW`, `H_MID`, `H_FAST` (defaults 20, 2 and 1, a 1:10:20 bit-rate ratio). Value 3 acts like 2. The rate is latched at start.
- R7: Only the line at index `cs_sel` (latched at start) goes low, and only while `busy` is high. No two lines are ever low together.
- R8: `done` is high for exactly one clock, on the edge where `busy` falls.
- R9: A start while `busy` is high is ignored. A start with `count` = 0 is ignored.
- R10: Host writes to the store while `busy` is high are ignored. `rd_data` always shows store byte `rd_addr` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled on the clock |
| count | input | CNT_W | Bits to transfer, 1..255 |
| edge_sel | input | 1 | 0: launch on rising sclk, 1: launch on falling sclk |
| rate_sel | input | 2 | Bit-rate choice |
| cs_sel | input | CS_W | Index of the chip-select line to drive |
| miso | input | 1 | Serial data from the target |
| wr_en | input | 1 | Store write enable |
| wr_addr | input | AW | Store write byte address |
| wr_data | input | 8 | Store write data |
| rd_addr | input | AW | Store read byte address |
| rd_data | output | 8 | Store read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| cs_n | output | CS_COUNT | Active-low chip selects |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
All serial outputs are registered, so every result is due a fixed number of clocks after the accepting edge c0. `cs_n` and `busy` change at c0. Launch edges and the resulting `mosi` values fall at c0+(2+2i)H, captures at c0+(3+2i)H, and `done` at c0+(2N+3)H. The bench's model computes these edge times from the latched count and rate and changes its predictions at the same edges. Outputs are compared on the falling clock in every cycle, which is half a period after the edge being checked. A separate count of falling clocks from start to `done` must equal (2N+3)H+1. The store is read back through the read port only after `busy` has dropped, with the unspecified low bits of the last byte masked.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  localparam logic [1:0] RATE_SLOW = 2'd0;
  localparam logic [1:0] RATE_MID  = 2'd1;

endpackage

// File: rtl/ser3w_ratediv.sv
module ser3w_ratediv #(
  parameter int unsigned H_SLOW = 20,
  parameter int unsigned H_MID  = 2,
  parameter int unsigned H_FAST = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  import ser3w_pkg::*;

  localparam int unsigned HMAX_A = (H_SLOW > H_MID) ? H_SLOW : H_MID;
  localparam int unsigned HMAX   = (HMAX_A > H_FAST) ? HMAX_A : H_FAST;
  localparam int unsigned HW     = $clog2(HMAX + 1);

  logic [1:0]    sel_q, sel_d;
  logic [HW-1:0] hc_q, hc_d;

  function automatic logic [HW-1:0] half_m1(input logic [1:0] s);
    if (s == RATE_SLOW)     return HW'(H_SLOW - 1);
    else if (s == RATE_MID) return HW'(H_MID - 1);
    else                    return HW'(H_FAST - 1);
  endfunction

  assign tick = run && (hc_q == '0);

  always_comb begin
    sel_d = sel_q;
    hc_d  = hc_q;
    if (load) begin
      sel_d = rate_sel;
      hc_d  = half_m1(rate_sel);
    end else if (run) begin
      if (hc_q == '0) hc_d = half_m1(sel_q);
      else            hc_d = hc_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      hc_q  <= '0;
    end else if (load || run) begin
      sel_q <= sel_d;
      hc_q  <= hc_d;
    end
  end

endmodule

// File: rtl/ser3w_seq.sv
module ser3w_seq #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned CS_COUNT = 8,
  parameter int unsigned CS_W     = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    count,
  input  logic                edge_sel,
  input  logic [CS_W-1:0]     cs_sel,
  input  logic                tick,
  output logic                load,
  output logic                busy,
  output logic                launch_en,
  output logic                capture_en,
  output logic [CNT_W-1:0]    bit_idx,
  output logic                sclk,
  output logic [CS_COUNT-1:0] cs_n,
  output logic                done
);
  import ser3w_pkg::*;

  localparam int unsigned KW = CNT_W + 2;

  seq_state_t          st_q, st_d;
  logic [KW-1:0]       k_q, k_d, kn, two_n;
  logic [CNT_W-1:0]    n_q, n_d;
  logic                pol_q, pol_d, ph_q, ph_d;
  logic [CS_W-1:0]     csi_q, csi_d;
  logic [CS_COUNT-1:0] cs_n_q, cs_n_d;
  logic                done_q, done_d;
  logic                in_run, step, toggle, finish;

  assign in_run = (st_q == ST_RUN);
  assign step   = in_run && tick;
  assign kn     = k_q + 1'b1;
  assign two_n  = {1'b0, n_q, 1'b0};

  assign load       = (st_q == ST_IDLE) && start && (count != '0);
  assign launch_en  = step && !kn[0] && (kn >= KW'(2)) && (kn <= two_n);
  assign capture_en = step &&  kn[0] && (kn >= KW'(3)) && (kn <= two_n + KW'(1));
  assign toggle     = step && (kn >= KW'(2)) && (kn <= two_n + KW'(1));
  assign finish     = step && (kn == two_n + KW'(3));
  assign bit_idx    = CNT_W'((kn >> 1) - KW'(1));

  always_comb begin
    st_d   = st_q;
    k_d    = k_q;
    n_d    = n_q;
    pol_d  = pol_q;
    ph_d   = ph_q;
    csi_d  = csi_q;
    done_d = 1'b0;
    if (load) begin
      st_d  = ST_RUN;
      k_d   = '0;
      n_d   = count;
      csi_d = cs_sel;
      ph_d  = 1'b0;
      pol_d = edge_sel;
    end else if (st_q == ST_IDLE) begin
      pol_d = edge_sel;
    end
    if (step)   k_d  = kn;
    if (toggle) ph_d = ~ph_q;
    if (finish) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
    end
    cs_n_d = '1;
    if (st_d == ST_RUN) cs_n_d[csi_d] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      n_q    <= '0;
      pol_q  <= 1'b0;
      ph_q   <= 1'b0;
      csi_q  <= '0;
      cs_n_q <= '1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      k_q    <= k_d;
      n_q    <= n_d;
      pol_q  <= pol_d;
      ph_q   <= ph_d;
      csi_q  <= csi_d;
      cs_n_q <= cs_n_d;
      done_q <= done_d;
    end
  end

  assign busy = in_run;
  assign sclk = pol_q ^ ph_q;
  assign cs_n = cs_n_q;
  assign done = done_q;

endmodule

// File: rtl/ser3w_buf.sv
module ser3w_buf #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned AW     = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  input  logic             launch_en,
  input  logic             capture_en,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic             miso,
  output logic             mosi
);
  localparam int unsigned NBYTES = 1 << AW;

  logic [7:0]    byte_view [NBYTES];
  logic [AW-1:0] byte_sel;
  logic [2:0]    pos;
  logic          mosi_q, mosi_d;

  assign byte_sel = bit_idx[CNT_W-1:3];
  assign pos      = ~bit_idx[2:0];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] q, nxt;
    logic       hit_wr, hit_cap;
    assign hit_wr  = wr_en && (wr_addr == AW'(g));
    assign hit_cap = capture_en && (byte_sel == AW'(g));
    always_comb begin
      nxt = q;
      if (hit_wr)  nxt = wr_data;
      if (hit_cap) nxt[pos] = miso;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (hit_wr || hit_cap) q <= nxt;
    end
    assign byte_view[g] = q;
  end

  always_comb begin
    mosi_d = mosi_q;
    if (launch_en) mosi_d = byte_view[byte_sel][pos];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mosi_q <= 1'b0;
    else if (launch_en) mosi_q <= mosi_d;
  end

  assign mosi    = mosi_q;
  assign rd_data = byte_view[rd_addr];

endmodule

// File: rtl/ser3w_master.sv
module ser3w_master #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned CS_COUNT = 8,
  parameter int unsigned H_SLOW   = 20,
  parameter int unsigned H_MID    = 2,
  parameter int unsigned H_FAST   = 1,
  parameter int unsigned AW       = CNT_W - 3,
  parameter int unsigned CS_W     = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    count,
  input  logic                edge_sel,
  input  logic [1:0]          rate_sel,
  input  logic [CS_W-1:0]     cs_sel,
  input  logic                miso,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [7:0]          rd_data,
  output logic                sclk,
  output logic                mosi,
  output logic [CS_COUNT-1:0] cs_n,
  output logic                busy,
  output logic                done
);

  logic rst_meta_q, rst_n_sync;
  logic load_w, tick_w, busy_w, launch_w, capture_w;
  logic [CNT_W-1:0] bit_idx_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  ser3w_ratediv #(
    .H_SLOW(H_SLOW), .H_MID(H_MID), .H_FAST(H_FAST)
  ) u_div (
    .clk(clk), .rst_n(rst_n_sync), .load(load_w), .run(busy_w),
    .rate_sel(rate_sel), .tick(tick_w)
  );

  ser3w_seq #(
    .CNT_W(CNT_W), .CS_COUNT(CS_COUNT), .CS_W(CS_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_sync), .start(start), .count(count),
    .edge_sel(edge_sel), .cs_sel(cs_sel), .tick(tick_w), .load(load_w),
    .busy(busy_w), .launch_en(launch_w), .capture_en(capture_w),
    .bit_idx(bit_idx_w), .sclk(sclk), .cs_n(cs_n), .done(done)
  );

  ser3w_buf #(
    .CNT_W(CNT_W), .AW(AW)
  ) u_buf (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en && !busy_w),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .launch_en(launch_w), .capture_en(capture_w),
    .bit_idx(bit_idx_w), .miso(miso), .mosi(mosi)
  );

  assign busy = busy_w;

endmodule

// File: rtl/ser3w_master_chk.sv
module ser3w_master_chk #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned CS_COUNT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [CNT_W-1:0]    count,
  input logic                edge_sel,
  input logic                sclk,
  input logic                mosi,
  input logic [CS_COUNT-1:0] cs_n,
  input logic                busy,
  input logic                done
);

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r7_select_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~cs_n) == 1));

  a_r7_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sclk == $past(edge_sel)));

  a_r3_mosi_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !$stable(sclk));

  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (count == '0)) |=> !busy);

  a_r9_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cs_n) || done));

endmodule

bind ser3w_master ser3w_master_chk #(
  .CNT_W(CNT_W), .CS_COUNT(CS_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .start(start), .count(count),
  .edge_sel(edge_sel), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .busy(busy), .done(done)
);

// File: tb/test_ser3w_master.sv
`timescale 1ns/1ps
module test_ser3w_master;

  logic       clk = 1'b0;
  logic       rst_n, start, edge_sel, miso, wr_en;
  logic [7:0] count, wr_data, rd_data;
  logic [1:0] rate_sel;
  logic [2:0] cs_sel;
  logic [4:0] wr_addr, rd_addr;
  logic       sclk, mosi, busy, done;
  logic [7:0] cs_n;

  always #2 clk = ~clk;

  ser3w_master i_ser3w_master (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .edge_sel(edge_sel), .rate_sel(rate_sel), .cs_sel(cs_sel), .miso(miso),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_on  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: edge times derived from requirement R5
  int         cyc, c0, mN, mH, m_cs;
  bit         m_busy, m_done, m_mosi, mpol;
  logic [7:0] mbuf [32];

  function automatic int half_of(input logic [1:0] rs);
    if (rs == 2'd0) return 20;
    if (rs == 2'd1) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_busy = 0; m_done = 0; m_mosi = 0; mpol = 0;
      for (int a = 0; a < 32; a++) mbuf[a] = 8'h00;
    end else begin
      bit was_busy;
      cyc++;
      m_done   = 0;
      was_busy = m_busy;
      if (!was_busy) mpol = edge_sel;
      if (was_busy) begin
        int d, k, i;
        d = cyc - c0;
        if (d % mH == 0) begin
          k = d / mH;
          if (k >= 2 && k % 2 == 0 && k <= 2*mN) begin
            i = (k - 2) / 2;
            m_mosi = mbuf[i/8][7 - i%8];
          end
          if (k >= 3 && k % 2 == 1 && k <= 2*mN + 1) begin
            i = (k - 3) / 2;
            mbuf[i/8][7 - i%8] = miso;
          end
          if (k == 2*mN + 3) begin
            m_busy = 0;
            m_done = 1;
          end
        end
      end else if (start && count != 0) begin
        m_busy = 1; c0 = cyc; mN = int'(count);
        mH = half_of(rate_sel); m_cs = int'(cs_sel);
      end
      if (!was_busy && wr_en) mbuf[wr_addr] = wr_data;
    end
  end

  function automatic bit exp_sclk();
    int d, k, t;
    if (!m_busy) return mpol;
    d = cyc - c0;
    k = d / mH;
    t = (k < 2) ? 0 : ((k - 1 > 2*mN) ? 2*mN : k - 1);
    return mpol ^ t[0];
  endfunction

  // per-cycle comparison, half a period after each active edge
  always @(negedge clk) begin
    if (chk_on) begin
      logic [7:0] ecs;
      ecs = m_busy ? ~(8'd1 << m_cs) : 8'hFF;
      chk(sclk == exp_sclk(), m_busy ? "R5" : "R2", "sclk", sclk, exp_sclk());
      chk(mosi == m_mosi, "R3", "mosi", mosi, m_mosi);
      chk(cs_n == ecs, "R7", "cs_n", cs_n, ecs);
      chk(busy == m_busy, "R9", "busy", busy, m_busy);
      chk(done == m_done, "R8", "done", done, m_done);
    end
  end

  // miso pattern source
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[0];
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic host_write(input int a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(a); wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic check_buf(input int n, input string tag);
    for (int a = 0; a < 32; a++) begin
      logic [7:0] mask;
      int filled;
      @(negedge clk);
      rd_addr = 5'(a);
      #1;
      mask = 8'hFF;
      if (a*8 < n) begin
        filled = (n - a*8 >= 8) ? 8 : n - a*8;
        mask = 8'hFF << (8 - filled);
      end
      chk((rd_data & mask) == (mbuf[a] & mask), tag, "store byte",
          int'(rd_data & mask), int'(mbuf[a] & mask));
    end
  endtask

  // drives one transfer; R6 latency = (2N+3)H+1 falling clocks to done
  task automatic run_xfer(input int n, input bit es, input logic [1:0] rs,
                          input int cs, input bit inject);
    int lat;
    @(negedge clk);
    edge_sel = es;
    @(negedge clk);
    count = 8'(n); rate_sel = rs; cs_sel = 3'(cs); start = 1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      start = 0;
      wr_en = 0;
      if (inject && lat == 10) begin
        start = 1; count = 8'd3; cs_sel = 3'd4;
        wr_en = 1; wr_addr = 5'd0; wr_data = 8'hA5;
      end
    end while (!done);
    chk(lat == (2*n + 3) * half_of(rs) + 1, "R6", "start-to-done clocks",
        lat, (2*n + 3) * half_of(rs) + 1);
    repeat (3) @(negedge clk);
    check_buf(n, inject ? "R10" : "R4");
  endtask

  initial begin
    rst_n = 0; start = 0; edge_sel = 0; count = 0; rate_sel = 0; cs_sel = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 8'hFF, "R1", "cs_n after reset", cs_n, 8'hFF);
    chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    chk(mosi == 1'b0, "R1", "mosi after reset", mosi, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    chk_on = 1;

    for (int a = 0; a < 32; a++) host_write(a, 8'(a * 59 + 90));
    check_buf(0, "R10");

    run_xfer(8,   0, 2'd2, 0, 0);
    run_xfer(13,  1, 2'd1, 5, 0);
    run_xfer(1,   0, 2'd0, 7, 0);
    run_xfer(20,  1, 2'd3, 2, 0);
    run_xfer(16,  0, 2'd2, 1, 1);   // R9 start and R10 write while busy

    // R9 zero count ignored
    @(negedge clk);
    count = 8'd0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after zero-count start", busy, 0);
    chk(cs_n == 8'hFF, "R9", "cs_n after zero-count start", cs_n, 8'hFF);

    run_xfer(255, 0, 2'd2, 3, 0);

    // R10 idle write reaches the read port without delay
    host_write(9, 8'h3C);
    rd_addr = 5'd9;
    #1;
    chk(rd_data == 8'h3C, "R10", "read after idle write", rd_data, 8'h3C);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule